// File: doc/BRIEF.md
# Partitioned SIMD Integer Multiplier

This block is a 64-bit integer multiplier whose partial-product array can be cut into independent lanes, so that one set of hardware serves several element sizes. A global wide bit joins the whole operand into a single 64x64 lane. When it is clear, the operand splits into a low half (bits 31:0) and a high half (bits 63:32), each with its own mode. A half runs as one 32-bit lane, two 16-bit lanes or four 8-bit lanes.

Every lane returns its full double-width product. For element width W, lane i's product is placed at result bits [2*W*i +: 2*W], which gives a 128-bit packed result. Two per-operand flags choose signed (two's complement) or unsigned interpretation. Sign extension applies only within each lane. Partial products whose bytes belong to different lanes are masked to zero, and carries are cut at every lane boundary of the result.

The array is intended to be shared with the significand multiply of a floating-point unit. It contains no exponent, rounding or normalisation logic. Results appear a fixed two cycles after a valid strobe.

Top module: `partitioned_multiplier`

## Requirements
- R1: A strobe on `inValid` in cycle t raises `outValid` in cycle t+2 together with the result for the operands captured in cycle t. A cycle with `inValid` low gives `outValid` low two cycles later. Strobes on consecutive cycles give results on consecutive cycles.
- R2: While `rst` is high at a clock edge, `outValid` and `product` are cleared to zero.
- R3: With `wide64` = 1, both half modes are ignored and `product` holds the 128-bit product of `opA` and `opB`.
- R4: With `wide64` = 0, a half mode of 2'b00 makes that half (low = bits 31:0, high = bits 63:32) one 32-bit lane. Its 64-bit product is placed at `product[63:0]` for the low half and at `product[127:64]` for the high half.
- R5: A half mode of 2'b01 makes that half two 16-bit lanes. Overall 16-bit lane k (operand bits [16k +: 16]) yields a 32-bit product at `product[32k +: 32]`.
- R6: A half mode of 2'b10 or 2'b11 makes that half four 8-bit lanes. Overall lane k (operand bits [8k +: 8]) yields a 16-bit product at `product[16k +: 16]`.
- R7: The two halves are configured independently, and any pairing of half modes yields correct lanes in both halves.
- R8: `signA` = 1 treats every lane of `opA` as two's complement, and `signA` = 0 treats it as unsigned. `signB` does the same for `opB`. Mixed signed-by-unsigned lanes are supported. Each lane result is the exact product taken modulo 2^(2W).
- R9: A lane's product does not depend on any operand bit outside that lane.
- R10: `product` holds its last value in every cycle in which no new result is delivered.
- R11: A zero in either operand of a lane gives a zero product in that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands and modes are valid this cycle |
| opA | input | 64 | Multiplicand, packed lanes |
| opB | input | 64 | Multiplier, packed lanes |
| signA | input | 1 | 1: lanes of opA are two's complement |
| signB | input | 1 | 1: lanes of opB are two's complement |
| wide64 | input | 1 | 1: single 64x64 lane, half modes ignored |
| modeLo | input | 2 | Low-half mode: 00 1x32, 01 2x16, 10/11 4x8 |
| modeHi | input | 2 | High-half mode, same encoding |
| outValid | output | 1 | product carries a new result |
| product | output | 128 | Packed double-width lane products |

## Verification
Two things can happen in the same cycle: the stage-one register captures a new operand set with a new lane configuration, and the output stage delivers the previous result, which was computed under a different configuration. The bench provokes this by strobing three operand sets on consecutive cycles, each with a different mode (8-bit halves, one 64-bit lane, mixed halves). It then checks each result against its own reference product in consecutive cycles, so a configuration that leaks from one stage into the next would corrupt the lanes. The bench also asserts reset on the cycle after a result and requires the cleared state, and it keeps `product` under observation while idle operands change.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_BYTES  = 8;
  localparam int HALF_BYTES = NUM_BYTES / 2;
  localparam int OP_W       = BYTE_W * NUM_BYTES;
  localparam int RES_W      = 2 * OP_W;
  localparam int SEG_W      = 2 * BYTE_W;
  localparam int PP_W       = 2 * (BYTE_W + 1);

  typedef enum logic [1:0] {
    HALF_X32   = 2'b00,
    HALF_X16   = 2'b01,
    HALF_X8    = 2'b10,
    HALF_X8ALT = 2'b11
  } half_mode_e;

  typedef struct packed {
    logic                 load;
    logic                 finish;
    logic                 signA;
    logic                 signB;
    logic [NUM_BYTES-1:0] laneStart;
    logic [NUM_BYTES-1:0] laneTop;
  } mul_strobe_t;
endpackage

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
  import lsm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        signA,
  input  logic        signB,
  input  logic        wide64,
  input  logic [1:0]  modeLo,
  input  logic [1:0]  modeHi,
  output mul_strobe_t strobe,
  output logic        outValid
);
  logic stageOne;
  logic stageTwo;
  logic [NUM_BYTES-1:0] startBits;
  logic [NUM_BYTES-1:0] topBits;

  // per-byte lane geometry decode
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic [1:0] halfSel;
    assign halfSel = (b < HALF_BYTES) ? modeLo : modeHi;
    always_comb begin
      int laneW;
      case (half_mode_e'(halfSel))
        HALF_X32: laneW = HALF_BYTES;
        HALF_X16: laneW = HALF_BYTES / 2;
        default:  laneW = 1;
      endcase
      if (wide64) laneW = NUM_BYTES;
      startBits[b] = ((b % laneW) == 0);
      topBits[b]   = ((b % laneW) == (laneW - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stageOne <= 1'b0;
      stageTwo <= 1'b0;
    end else begin
      stageOne <= inValid;
      stageTwo <= stageOne;
    end
  end

  always_comb begin
    strobe.load      = inValid;
    strobe.finish    = stageOne;
    strobe.signA     = signA;
    strobe.signB     = signB;
    strobe.laneStart = startBits;
    strobe.laneTop   = topBits;
  end

  assign outValid = stageTwo;

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##2 outValid); // R1
  AST_IDLE_DELAY: assert property (@(posedge clk) disable iff (rst)
    !inValid |-> ##2 !outValid); // R1
endmodule

// File: rtl/lsm_datapath.sv
module lsm_datapath
  import lsm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  mul_strobe_t      strobe,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  output logic [RES_W-1:0] product
);
  logic [OP_W-1:0]      aReg;
  logic [OP_W-1:0]      bReg;
  logic                 sAReg;
  logic                 sBReg;
  logic [NUM_BYTES-1:0] startReg;
  logic [NUM_BYTES-1:0] topReg;
  logic [RES_W-1:0]     sumNext;
  int                   laneBase  [NUM_BYTES];
  int                   laneBytes [NUM_BYTES];

  // adder whose carry chain is broken at every lane start segment
  function automatic logic [RES_W-1:0] cutAdd(input logic [RES_W-1:0] x,
                                              input logic [RES_W-1:0] y,
                                              input logic [NUM_BYTES-1:0] cuts);
    logic [RES_W-1:0] res;
    logic             carry;
    logic [SEG_W:0]   part;
    res   = '0;
    carry = 1'b0;
    for (int s = 0; s < NUM_BYTES; s++) begin
      if (cuts[s]) carry = 1'b0;
      part = {1'b0, x[s*SEG_W +: SEG_W]} + {1'b0, y[s*SEG_W +: SEG_W]}
           + {{SEG_W{1'b0}}, carry};
      res[s*SEG_W +: SEG_W] = part[SEG_W-1:0];
      carry = part[SEG_W];
    end
    return res;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      aReg     <= opA;
      bReg     <= opB;
      sAReg    <= strobe.signA;
      sBReg    <= strobe.signB;
      startReg <= strobe.laneStart;
      topReg   <= strobe.laneTop;
    end
  end

  // lane base byte and lane length for each byte position
  always_comb begin
    for (int i = 0; i < NUM_BYTES; i++) begin
      int base;
      int nxt;
      base = 0;
      nxt  = NUM_BYTES;
      for (int k = 0; k <= i; k++)
        if (startReg[k]) base = k;
      for (int k = NUM_BYTES - 1; k > i; k--)
        if (startReg[k]) nxt = k;
      laneBase[i]  = base;
      laneBytes[i] = nxt - base;
    end
  end

  // masked byte partial products, summed with lane-cut carries
  always_comb begin
    logic [RES_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      for (int j = 0; j < NUM_BYTES; j++) begin
        logic signed [BYTE_W:0] xa;
        logic signed [BYTE_W:0] xb;
        logic signed [PP_W-1:0] pp;
        logic [RES_W-1:0]       term;
        logic [RES_W-1:0]       fieldMask;
        int                     shiftAmt;
        xa = $signed({topReg[i] & sAReg & aReg[i*BYTE_W + BYTE_W - 1],
                      aReg[i*BYTE_W +: BYTE_W]});
        xb = $signed({topReg[j] & sBReg & bReg[j*BYTE_W + BYTE_W - 1],
                      bReg[j*BYTE_W +: BYTE_W]});
        pp = xa * xb;
        shiftAmt  = BYTE_W * (2 * laneBase[i] + (i - laneBase[i]) + (j - laneBase[j]));
        fieldMask = ((RES_W'(1) << (SEG_W * laneBytes[i])) - RES_W'(1))
                    << (SEG_W * laneBase[i]);
        term = ({{(RES_W-PP_W){pp[PP_W-1]}}, pp} << shiftAmt) & fieldMask;
        if (laneBase[i] != laneBase[j]) term = '0;
        acc = cutAdd(acc, term, startReg);
      end
    end
    sumNext = acc;
  end

  always_ff @(posedge clk) begin
    if (rst) product <= '0;
    else if (strobe.finish) product <= sumNext;
  end

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !strobe.finish |=> $stable(product)); // R10
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (strobe.finish && aReg == '0) |=> (product == '0)); // R11
  AST_BYTE_LANE: assert property (@(posedge clk) disable iff (rst)
    (strobe.finish && startReg[1] && !sAReg && !sBReg) |=>
    (product[SEG_W-1:0] == $past({{BYTE_W{1'b0}}, aReg[BYTE_W-1:0]} *
                                 {{BYTE_W{1'b0}}, bReg[BYTE_W-1:0]}))); // R6
endmodule

// File: rtl/partitioned_multiplier.sv
module partitioned_multiplier
  import lsm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  input  logic             signA,
  input  logic             signB,
  input  logic             wide64,
  input  logic [1:0]       modeLo,
  input  logic [1:0]       modeHi,
  output logic             outValid,
  output logic [RES_W-1:0] product
);
  mul_strobe_t strobe;

  lsm_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .signA    (signA),
    .signB    (signB),
    .wide64   (wide64),
    .modeLo   (modeLo),
    .modeHi   (modeHi),
    .strobe   (strobe),
    .outValid (outValid)
  );

  lsm_datapath u_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .product (product)
  );
endmodule

// File: tb/partitioned_multiplier_test.sv
`timescale 1ns/1ps
module partitioned_multiplier_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [63:0]  opA = '0;
  logic [63:0]  opB = '0;
  logic         signA = 1'b0;
  logic         signB = 1'b0;
  logic         wide64 = 1'b0;
  logic [1:0]   modeLo = 2'b00;
  logic [1:0]   modeHi = 2'b00;
  logic         outValid;
  logic [127:0] product;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  partitioned_multiplier uut (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .signA(signA), .signB(signB), .wide64(wide64), .modeLo(modeLo),
    .modeHi(modeHi), .outValid(outValid), .product(product)
  );

  function automatic logic [127:0] refMul(input logic [63:0] a, input logic [63:0] b,
                                          input logic sa, input logic sb, input logic wide,
                                          input logic [1:0] mlo, input logic [1:0] mhi);
    logic [127:0] r;
    r = '0;
    for (int byteIdx = 0; byteIdx < 8; byteIdx++) begin
      int w;
      logic [1:0] m;
      m = (byteIdx < 4) ? mlo : mhi;
      w = (m == 2'b00) ? 4 : (m == 2'b01) ? 2 : 1;
      if (wide) w = 8;
      if ((byteIdx % w) == 0) begin
        int bits;
        logic [127:0] mask, mask2, ea, eb, p;
        bits  = 8 * w;
        mask  = (128'(1) << bits) - 128'(1);
        mask2 = (128'(1) << (2 * bits)) - 128'(1);
        ea = (128'(a) >> (8 * byteIdx)) & mask;
        eb = (128'(b) >> (8 * byteIdx)) & mask;
        if (sa && ea[bits-1]) ea = ea | ~mask;
        if (sb && eb[bits-1]) eb = eb | ~mask;
        p = ea * eb;
        r = r | ((p & mask2) << (16 * byteIdx));
      end
    end
    return r;
  endfunction

  task automatic checkVal(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setOps(input logic [63:0] a, input logic [63:0] b, input logic sa,
                        input logic sb, input logic wide, input logic [1:0] mlo,
                        input logic [1:0] mhi);
    opA = a; opB = b; signA = sa; signB = sb; wide64 = wide; modeLo = mlo; modeHi = mhi;
  endtask

  // one strobe, checks latency and every lane against the reference
  task automatic runCase(input string req, input logic [63:0] a, input logic [63:0] b,
                         input logic sa, input logic sb, input logic wide,
                         input logic [1:0] mlo, input logic [1:0] mhi,
                         output logic [127:0] got);
    @(negedge clk);
    setOps(a, b, sa, sb, wide, mlo, mhi);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkVal({req, " R1 early"}, 128'(outValid), 128'(0));
    @(negedge clk);
    checkVal({req, " R1 valid"}, 128'(outValid), 128'(1));
    checkVal(req, product, refMul(a, b, sa, sb, wide, mlo, mhi));
    got = product;
  endtask

  task automatic testReset();
    logic [127:0] got;
    checkVal("R2 outValid at reset", 128'(outValid), 128'(0));
    checkVal("R2 product at reset", product, 128'(0));
    runCase("R2 pre", 64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321, 0, 0, 1, 0, 0, got);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checkVal("R2 product cleared", product, 128'(0));
    checkVal("R2 outValid cleared", 128'(outValid), 128'(0));
  endtask

  task automatic testWide();
    logic [127:0] got;
    runCase("R3 wide unsigned", 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 0, 0, 1, 2'b10, 2'b01, got);
    runCase("R3 wide signed ones", 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 1, 1, 1, 2'b01, 2'b10, got);
    checkVal("R8 signed -1*-1", got, 128'(1));
    runCase("R8 wide min*min", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1, 1, 1, 0, 0, got);
    checkVal("R8 min*min value", got, 128'(1) << 126);
    runCase("R3 wide random", 64'h0123_4567_89ab_cdef, 64'hdead_beef_cafe_f00d, 1, 0, 1, 2'b11, 2'b11, got);
  endtask

  task automatic testHalfModes();
    logic [127:0] got;
    runCase("R4 2x32 unsigned", 64'hffff_ffff_8000_0000, 64'hffff_ffff_8000_0000, 0, 0, 0, 0, 0, got);
    runCase("R4 2x32 signed", 64'h8000_0000_ffff_ffff, 64'h8000_0000_7fff_ffff, 1, 1, 0, 0, 0, got);
    runCase("R5 4x16 signed", 64'h8000_ffff_7fff_0001, 64'h8000_ffff_8000_ffff, 1, 1, 0, 1, 1, got);
    runCase("R6 8x8 mode10", 64'hff80_7f01_00ff_8012, 64'hff80_807f_ff02_8034, 1, 1, 0, 2, 2, got);
    runCase("R6 8x8 mode11", 64'hff80_7f01_00ff_8012, 64'hff80_807f_ff02_8034, 0, 0, 0, 3, 3, got);
    checkVal("R6 lane0 0x12*0x34", 128'(got[15:0]), 128'(16'h03a8));
  endtask

  task automatic testMixed();
    logic [127:0] got;
    runCase("R7 lo8 hi32", 64'h89ab_cdef_fe80_7f81, 64'h7654_3210_8180_ff02, 1, 1, 0, 2, 0, got);
    runCase("R7 lo32 hi16", 64'h8001_7fff_dead_beef, 64'hffff_8000_1234_5678, 1, 0, 0, 0, 1, got);
    runCase("R7 lo16 hi8", 64'h80ff_017f_ffff_8000, 64'hff80_7f01_8000_ffff, 0, 1, 0, 1, 3, got);
  endtask

  task automatic testSignMix();
    logic [127:0] got;
    // signed 0x80 (-128) times unsigned 0xff (255) = -32640 = 0x8080 mod 2^16
    runCase("R8 s*u bytes", 64'h8080_8080_8080_8080, 64'hffff_ffff_ffff_ffff, 1, 0, 0, 2, 2, got);
    checkVal("R8 s*u lane value", 128'(got[15:0]), 128'(16'h8080));
    runCase("R8 u*s bytes", 64'hffff_ffff_ffff_ffff, 64'h8080_8080_8080_8080, 0, 1, 0, 2, 2, got);
  endtask

  task automatic testIsolation();
    logic [127:0] first, second;
    runCase("R9 base", 64'h0000_0000_0000_00c3, 64'h0000_0000_0000_005a, 1, 1, 0, 2, 2, first);
    runCase("R9 disturbed", 64'hffff_ffff_ffff_ffc3, 64'h8080_8080_8080_805a, 1, 1, 0, 2, 2, second);
    checkVal("R9 lane0 unaffected", 128'(second[15:0]), 128'(first[15:0]));
    runCase("R9 base16", 64'h0000_0000_0000_9abc, 64'h0000_0000_0000_8001, 1, 0, 0, 1, 1, first);
    runCase("R9 disturbed16", 64'hffff_8000_7fff_9abc, 64'hffff_ffff_ffff_8001, 1, 0, 0, 1, 1, second);
    checkVal("R9 lane16 unaffected", 128'(second[31:0]), 128'(first[31:0]));
  endtask

  task automatic testHold();
    logic [127:0] got;
    runCase("R10 setup", 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 0, 0, 0, 1, 2, got);
    for (int cyc = 0; cyc < 5; cyc++) begin
      @(negedge clk);
      setOps(64'(cyc) * 64'h0101_0101_0101_0101 + 64'hff, 64'hffff_0000_ffff_0000, 1, 1, 1, 0, 0);
    end
    @(negedge clk);
    checkVal("R10 held product", product, got);
    checkVal("R10 idle outValid", 128'(outValid), 128'(0));
  endtask

  task automatic testZero();
    logic [127:0] got;
    runCase("R11 zero wide", 64'h0, 64'hffff_ffff_ffff_ffff, 1, 1, 1, 0, 0, got);
    checkVal("R11 zero wide value", got, 128'(0));
    runCase("R11 zero lanes", 64'h00ff_0080_0000_ff00, 64'hff00_ff00_ffff_00ff, 1, 1, 0, 2, 3, got);
    checkVal("R11 zero lane values", got, 128'(0));
  endtask

  // capture and result emission fall in the same cycle with different modes
  task automatic testBackToBack();
    logic [63:0] aS [3];
    logic [63:0] bS [3];
    logic wS [3];
    logic [1:0] loS [3];
    logic [1:0] hiS [3];
    aS[0] = 64'h80ff_7f01_8000_ffff; bS[0] = 64'h7f80_ff01_ffff_8000; wS[0] = 0; loS[0] = 2; hiS[0] = 2;
    aS[1] = 64'hfedc_ba98_7654_3210; bS[1] = 64'h8000_0000_0000_0001; wS[1] = 1; loS[1] = 2; hiS[1] = 2;
    aS[2] = 64'h8000_0001_8000_7fff; bS[2] = 64'hffff_ffff_8001_8000; wS[2] = 0; loS[2] = 1; hiS[2] = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        checkVal("R1 back-to-back valid", 128'(outValid), 128'(1));
        checkVal("R1 back-to-back product", product,
                 refMul(aS[k-2], bS[k-2], 1, 1, wS[k-2], loS[k-2], hiS[k-2]));
      end
      if (k < 3) begin
        setOps(aS[k], bS[k], 1, 1, wS[k], loS[k], hiS[k]);
        inValid = 1'b1;
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    checkVal("R1 stream ends", 128'(outValid), 128'(0));
  endtask

  task automatic testRandom();
    logic [127:0] got;
    for (int it = 0; it < 80; it++) begin
      logic [63:0] a, b;
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      if (it % 7 == 0) a = 64'h8000_8000_8080_8000;
      if (it % 11 == 0) b = 64'hffff_ffff_ffff_ffff;
      runCase("R7 random combo", a, b, 1'($urandom()), 1'($urandom()), (it % 17) == 0,
              2'(it % 4), 2'((it / 4) % 4), got);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    testWide();
    testHalfModes();
    testMixed();
    testSignMix();
    testIsolation();
    testHold();
    testZero();
    testBackToBack();
    testRandom();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule